// File: doc/BRIEF.md
# Power Mode Controller

This block decides which power mode a power-management device is in and issues the control strobes and enables that go with that mode. It watches the following inputs:

- a push-button level;
- two supply-present levels, USB and AC;
- a host power-enable pin and an active-low reset pin;
- a software bit that selects whether the next power-down goes to OFF or to SLEEP;
- three fault flags;
- the low-power-regulator request bit from the register file;
- a slow tick that serves as the time base.

From these it drives a wake request to the host, enables for the rails that the sequencer does not handle and for the low-power always-on regulator, trigger pulses for the rail sequencer in both directions, a register-reset pulse and a serial-interface enable.

The modes are OFF, WAKE (the host acknowledge window), ACTIVE, PDOWN (the power-down that leads to SLEEP), SLEEP and RESET. Every asynchronous input passes through a two-flop synchronizer. All durations are counted in ticks, and `TICKS_PER_SEC` sets how many ticks make one second. The block has no data path and no handshake; every pin is a plain level or a single-cycle pulse.

Top module: `pmc_ctrl`

## Requirements
- R1: After `rst_n` the block is in OFF: `wake_pull`, `nsq_en`, `aon_ldo_en`, `ser_en`, `seq_up`, `seq_down` and `reg_rst` are all 0.
- R2: In OFF with no fault, a wake event moves the block to WAKE. A wake event is a falling `pb_n`, a rising `usb_ok` or a rising `ac_ok`. In WAKE, `wake_pull`, `nsq_en` and `ser_en` are 1. A supply input that stays high without a new rising edge does not wake the block.
- R3: In WAKE, a high `pwr_en` moves the block to ACTIVE. `wake_pull` returns to 0 and `seq_up` pulses once.
- R4: If `pwr_en` stays low for 5 s of ticks in WAKE, the block goes to OFF. `seq_down` and `reg_rst` pulse, and `nsq_en` and `ser_en` drop.
- R5: In ACTIVE, a low `pwr_en` with `off_sel`=1 moves the block to OFF, with one `seq_down` pulse and one `reg_rst` pulse.
- R6: In ACTIVE, a low `pwr_en` with `off_sel`=0 pulses `seq_down` at once and enters SLEEP 1 s of ticks later. `reg_rst` pulses on the SLEEP entry. `nsq_en` and `ser_en` stay 1 throughout.
- R7: `aon_ldo_en` follows `aon_req` in WAKE, ACTIVE and PDOWN. In SLEEP it holds the value `aon_req` had on SLEEP entry. In OFF and RESET it is 0.
- R8: In SLEEP, a high `pwr_en` returns the block to ACTIVE with a `seq_up` pulse, and a wake event moves it to WAKE.
- R9: Any of `flt_thermal`, `flt_pgood` or `flt_uvlo` forces OFF. Wake events are ignored while a fault is present. Once the fault clears, only a new wake event leaves OFF.
- R10: In any mode except OFF, a low `rst_pin_n` enters RESET. `nsq_en` and `ser_en` drop, and `seq_down` and `reg_rst` pulse. In OFF, `rst_pin_n` has no effect.
- R11: RESET lasts while `rst_pin_n` is low and for at least 1 s of ticks. It then goes to WAKE, never to OFF.
- R12: While `pb_n` stays low, the block enters RESET once for every 8 s of ticks counted from the fall.
- R13: A fault and a host acknowledge that arrive in the same cycle in WAKE resolve to OFF, and no `seq_up` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| pb_n | input | 1 | Push-button level, low when pressed |
| usb_ok | input | 1 | USB supply present |
| ac_ok | input | 1 | AC adapter present |
| pwr_en | input | 1 | Host power-enable |
| rst_pin_n | input | 1 | Active-low reset pin |
| off_sel | input | 1 | 1: power-down goes to OFF; 0: to SLEEP |
| aon_req | input | 1 | Always-on regulator enable from register file |
| flt_thermal | input | 1 | Thermal shutdown fault |
| flt_pgood | input | 1 | Power-good failure fault |
| flt_uvlo | input | 1 | Undervoltage lockout fault |
| wake_pull | output | 1 | 1 pulls the open-drain wake line low |
| nsq_en | output | 1 | Enable for rails not under sequencer control |
| aon_ldo_en | output | 1 | Always-on low-power regulator enable |
| seq_up | output | 1 | Power-up sequencer trigger pulse |
| seq_down | output | 1 | Power-down sequencer trigger pulse |
| reg_rst | output | 1 | Register-file reset pulse |
| ser_en | output | 1 | Serial-interface enable |

## Verification
A fault flag and the host power-enable can arrive in the same cycle while the block sits in WAKE. The first asks for OFF and the second for ACTIVE. The bench drives both inputs on the same edge, so both pass through identical synchronizer delays and reach the next-state logic together. The case passes when the block lands in OFF with a `seq_down`/`reg_rst` pair, and the scoreboard, which rejects any event it did not expect, sees no `seq_up` at all.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_WAKE  = 3'd1,
    MD_ACT   = 3'd2,
    MD_PDOWN = 3'd3,
    MD_SLEEP = 3'd4,
    MD_RST   = 3'd5
  } pmc_mode_e;

  // synchronizer lane order
  localparam int LN_PB    = 7;
  localparam int LN_USB   = 6;
  localparam int LN_AC    = 5;
  localparam int LN_PWR   = 4;
  localparam int LN_RPIN  = 3;
  localparam int LN_FTHM  = 2;
  localparam int LN_FPG   = 1;
  localparam int LN_FUV   = 0;
  localparam int N_LANES  = 8;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pmc_wakedet.sv
module pmc_wakedet (
  input  logic clk,
  input  logic rst_n,
  input  logic pb_s,
  input  logic usb_s,
  input  logic ac_s,
  output logic wake_ev
);
  logic pb_d, usb_d, ac_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_d  <= 1'b1;
      usb_d <= 1'b0;
      ac_d  <= 1'b0;
    end else begin
      pb_d  <= pb_s;
      usb_d <= usb_s;
      ac_d  <= ac_s;
    end
  end

  assign wake_ev = (pb_d & ~pb_s) | (~usb_d & usb_s) | (~ac_d & ac_s);
endmodule

// File: rtl/pmc_presstimer.sv
module pmc_presstimer #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LONG_SEC      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic held,
  output logic hit
);
  localparam int LIM = TICKS_PER_SEC * LONG_SEC;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(LIM - 1));
  assign hit    = held & tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!held)   cnt <= '0;
    else if (tick)    cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R12: a long-press report restarts the period from zero
  p_lp_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WAKE_SEC      = 5,
  parameter int PDOWN_SEC     = 1,
  parameter int RST_MIN_SEC   = 1,
  parameter int LONG_SEC      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pb_n,
  input  logic usb_ok,
  input  logic ac_ok,
  input  logic pwr_en,
  input  logic rst_pin_n,
  input  logic off_sel,
  input  logic aon_req,
  input  logic flt_thermal,
  input  logic flt_pgood,
  input  logic flt_uvlo,
  output logic wake_pull,
  output logic nsq_en,
  output logic aon_ldo_en,
  output logic seq_up,
  output logic seq_down,
  output logic reg_rst,
  output logic ser_en
);
  import pmc_pkg::*;

  localparam int WAKE_T  = WAKE_SEC * TICKS_PER_SEC;
  localparam int PDOWN_T = PDOWN_SEC * TICKS_PER_SEC;
  localparam int RDWL_T  = RST_MIN_SEC * TICKS_PER_SEC;
  localparam int CMAX    = (WAKE_T > PDOWN_T) ? ((WAKE_T > RDWL_T) ? WAKE_T : RDWL_T)
                                              : ((PDOWN_T > RDWL_T) ? PDOWN_T : RDWL_T);
  localparam int DW      = $clog2(CMAX + 1);
  localparam logic [N_LANES-1:0] SYNC_RST = (N_LANES'(1) << LN_PB) | (N_LANES'(1) << LN_RPIN);

  logic [N_LANES-1:0] raw, syn;
  logic pb_s, usb_s, ac_s, pwr_s, rpin_s, flt_any;
  logic wake_ev, lp_hit, rst_req;

  assign raw = {pb_n, usb_ok, ac_ok, pwr_en, rst_pin_n, flt_thermal, flt_pgood, flt_uvlo};

  pmc_sync #(.W(N_LANES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign pb_s    = syn[LN_PB];
  assign usb_s   = syn[LN_USB];
  assign ac_s    = syn[LN_AC];
  assign pwr_s   = syn[LN_PWR];
  assign rpin_s  = syn[LN_RPIN];
  assign flt_any = syn[LN_FTHM] | syn[LN_FPG] | syn[LN_FUV];

  pmc_wakedet u_wake (
    .clk(clk), .rst_n(rst_n), .pb_s(pb_s), .usb_s(usb_s), .ac_s(ac_s), .wake_ev(wake_ev)
  );

  pmc_presstimer #(.TICKS_PER_SEC(TICKS_PER_SEC), .LONG_SEC(LONG_SEC)) u_press (
    .clk(clk), .rst_n(rst_n), .tick(tick), .held(~pb_s), .hit(lp_hit)
  );

  assign rst_req = ~rpin_s | lp_hit;

  pmc_mode_e     st_q, st_d;
  logic [DW-1:0] dwell_q;
  logic          wake_to, pdown_to, rdwl_ok;
  logic          up_q, dn_q, rr_q, aon_hold_q;
  logic          entering;

  assign wake_to  = tick && (dwell_q == DW'(WAKE_T - 1));
  assign pdown_to = tick && (dwell_q == DW'(PDOWN_T - 1));
  assign rdwl_ok  = (dwell_q >= DW'(RDWL_T));

  always_comb begin
    st_d = st_q;
    if (st_q == MD_OFF) begin
      if (wake_ev && !flt_any) st_d = MD_WAKE;
    end else if (flt_any) begin
      st_d = MD_OFF;
    end else if (rst_req && st_q != MD_RST) begin
      st_d = MD_RST;
    end else begin
      unique case (st_q)
        MD_WAKE:  if (pwr_s) st_d = MD_ACT;
                  else if (wake_to) st_d = MD_OFF;
        MD_ACT:   if (!pwr_s) st_d = off_sel ? MD_OFF : MD_PDOWN;
        MD_PDOWN: if (pdown_to) st_d = MD_SLEEP;
        MD_SLEEP: if (pwr_s) st_d = MD_ACT;
                  else if (wake_ev) st_d = MD_WAKE;
        MD_RST:   if (rdwl_ok && rpin_s) st_d = MD_WAKE;
        default:  st_d = MD_OFF;
      endcase
    end
  end

  assign entering = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MD_OFF;
      dwell_q    <= '0;
      up_q       <= 1'b0;
      dn_q       <= 1'b0;
      rr_q       <= 1'b0;
      aon_hold_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (entering)                        dwell_q <= '0;
      else if (tick && dwell_q != DW'(CMAX)) dwell_q <= dwell_q + 1'b1;
      up_q <= entering && (st_d == MD_ACT);
      dn_q <= entering && (st_d == MD_OFF || st_d == MD_PDOWN || st_d == MD_RST);
      rr_q <= entering && (st_d == MD_OFF || st_d == MD_SLEEP || st_d == MD_RST);
      if (entering && st_d == MD_SLEEP) aon_hold_q <= aon_req;
    end
  end

  assign wake_pull  = (st_q == MD_WAKE);
  assign nsq_en     = (st_q != MD_OFF) && (st_q != MD_RST);
  assign ser_en     = (st_q != MD_OFF) && (st_q != MD_RST);
  assign aon_ldo_en = (st_q == MD_SLEEP) ? aon_hold_q :
                      (st_q == MD_WAKE || st_q == MD_ACT || st_q == MD_PDOWN) ? aon_req : 1'b0;
  assign seq_up     = up_q;
  assign seq_down   = dn_q;
  assign reg_rst    = rr_q;

  // R9: a synchronized fault lands in OFF on the next edge
  p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_any |=> (st_q == MD_OFF));

  // R3: a clean acknowledge in WAKE gives ACTIVE with a power-up strobe
  p_wake_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MD_WAKE && pwr_s && !flt_any && !rst_req) |=> (st_q == MD_ACT && seq_up));

  // R7: the always-on enable does not move while SLEEP persists
  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MD_SLEEP && $past(st_q) == MD_SLEEP) |-> $stable(aon_ldo_en));

  // R11: RESET is kept while the pin is still low
  p_rst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MD_RST && !rpin_s && !flt_any) |=> (st_q == MD_RST));

  // R13: fault and acknowledge together never strobe power-up
  p_fault_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MD_WAKE && flt_any) |=> !seq_up);
endmodule

// File: tb/pmc_ctrl_tb.sv
module pmc_ctrl_tb;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pb_n = 1'b1, usb_ok = 1'b0, ac_ok = 1'b0, pwr_en = 1'b0, rst_pin_n = 1'b1;
  logic off_sel = 1'b0, aon_req = 1'b0;
  logic flt_thermal = 1'b0, flt_pgood = 1'b0, flt_uvlo = 1'b0;
  logic wake_pull, nsq_en, aon_ldo_en, seq_up, seq_down, reg_rst, ser_en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int exp_q[$];

  localparam int EV_UP = 1;
  localparam int EV_DN = 2;
  localparam int EV_RR = 3;

  always #2 clk = ~clk;

  pmc_ctrl #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pb_n(pb_n), .usb_ok(usb_ok), .ac_ok(ac_ok),
    .pwr_en(pwr_en), .rst_pin_n(rst_pin_n), .off_sel(off_sel), .aon_req(aon_req),
    .flt_thermal(flt_thermal), .flt_pgood(flt_pgood), .flt_uvlo(flt_uvlo),
    .wake_pull(wake_pull), .nsq_en(nsq_en), .aon_ldo_en(aon_ldo_en), .seq_up(seq_up),
    .seq_down(seq_down), .reg_rst(reg_rst), .ser_en(ser_en)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      tick = (c == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic take(input int code);
    if (exp_q.size() == 0) chk(1'b0, "scoreboard unexpected event", code, 0);
    else begin
      int e = exp_q.pop_front();
      chk(e == code, "scoreboard event order", code, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (seq_down) take(EV_DN);
      if (reg_rst)  take(EV_RR);
      if (seq_up)   take(EV_UP);
    end
  end

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_off();
    exp_q.push_back(EV_DN);
    exp_q.push_back(EV_RR);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    wc(3);
    rst_n = 1'b1;
    wc(3);
    // R1 reset state
    chk({wake_pull, nsq_en, aon_ldo_en, ser_en, seq_up, seq_down, reg_rst} == 7'b0, "R1 reset outputs",
        {wake_pull, nsq_en, aon_ldo_en, ser_en, seq_up, seq_down, reg_rst}, 0);

    // R2 wake by USB rising edge
    usb_ok = 1'b1; wc(6);
    chk(wake_pull && nsq_en && ser_en, "R2 usb wake", {wake_pull, nsq_en, ser_en}, 7);
    // R3 acknowledge
    exp_q.push_back(EV_UP);
    pwr_en = 1'b1; wc(6);
    chk(!wake_pull && ser_en, "R3 active, wake released", {wake_pull, ser_en}, 1);
    aon_req = 1'b1; wc(2);
    chk(aon_ldo_en == 1'b1, "R7 follows request in ACTIVE", aon_ldo_en, 1);

    // R6 power-down into SLEEP
    off_sel = 1'b0;
    push_off();
    pwr_en = 1'b0; wc(8);
    chk(exp_q.size() == 1, "R6 register reset not before 1 s", exp_q.size(), 1);
    chk(nsq_en && ser_en, "R6 rails kept in PDOWN", {nsq_en, ser_en}, 3);
    wc(22);
    chk(exp_q.size() == 0, "R6 register reset on SLEEP entry", exp_q.size(), 0);
    aon_req = 1'b0; wc(3);
    chk(aon_ldo_en == 1'b1, "R7 held in SLEEP", aon_ldo_en, 1);
    chk(nsq_en && ser_en, "R6 rails kept in SLEEP", {nsq_en, ser_en}, 3);

    // R8 SLEEP to ACTIVE by power-enable
    exp_q.push_back(EV_UP);
    pwr_en = 1'b1; wc(6);
    chk(!wake_pull && ser_en && exp_q.size() == 0, "R8 sleep to active", {wake_pull, ser_en}, 1);

    // R5 ACTIVE to OFF
    off_sel = 1'b1;
    push_off();
    pwr_en = 1'b0; wc(6);
    chk(!ser_en && !nsq_en && !aon_ldo_en, "R5 off reached", {ser_en, nsq_en, aon_ldo_en}, 0);
    wc(10);
    chk(!ser_en, "R2 level without edge does not wake", ser_en, 0);

    // R4 wake window expiry, woken by AC edge
    usb_ok = 1'b0;
    push_off();
    ac_ok = 1'b1; wc(60);
    chk(wake_pull == 1'b1, "R2 ac wake, window still open", wake_pull, 1);
    wc(40);
    chk(!ser_en && !nsq_en && exp_q.size() == 0, "R4 timeout to OFF", {ser_en, nsq_en}, 0);
    ac_ok = 1'b0;

    // R9 fault blocks wake
    flt_uvlo = 1'b1; wc(4);
    pb_n = 1'b0; wc(10);
    chk(!ser_en, "R9 wake ignored during fault", ser_en, 0);
    pb_n = 1'b1; wc(4);
    flt_uvlo = 1'b0; wc(10);
    chk(!ser_en, "R9 fresh event needed after clear", ser_en, 0);
    pb_n = 1'b0; wc(6);
    chk(wake_pull == 1'b1, "R2 push-button wake", wake_pull, 1);
    pb_n = 1'b1; wc(4);

    // R13 fault and acknowledge in the same cycle
    push_off();
    flt_thermal = 1'b1; pwr_en = 1'b1; wc(8);
    chk(!ser_en && exp_q.size() == 0, "R13 fault wins over ack", ser_en, 0);
    flt_thermal = 1'b0; pwr_en = 1'b0; wc(6);

    // R10 reset pin from ACTIVE
    pb_n = 1'b0; wc(4); pb_n = 1'b1; wc(4);
    exp_q.push_back(EV_UP);
    pwr_en = 1'b1; wc(8);
    push_off();
    rst_pin_n = 1'b0; wc(8);
    chk(!ser_en && !nsq_en, "R10 reset entered", {ser_en, nsq_en}, 0);
    wc(40);
    chk(!ser_en, "R11 held while pin low", ser_en, 0);
    exp_q.push_back(EV_UP);
    rst_pin_n = 1'b1; wc(30);
    chk(ser_en && !wake_pull && exp_q.size() == 0, "R11 back through wake to active", ser_en, 1);

    // R11 minimum dwell with a short pin pulse
    push_off();
    exp_q.push_back(EV_UP);
    rst_pin_n = 1'b0; wc(2); rst_pin_n = 1'b1; wc(8);
    chk(!ser_en, "R11 minimum dwell", ser_en, 0);
    wc(22);
    chk(ser_en == 1'b1 && exp_q.size() == 0, "R11 exit after dwell", ser_en, 1);

    // R10 reset pin in OFF has no effect
    off_sel = 1'b1;
    push_off();
    pwr_en = 1'b0; wc(8);
    rst_pin_n = 1'b0; wc(4); rst_pin_n = 1'b1; wc(10);
    chk(!ser_en && exp_q.size() == 0, "R10 pin ignored in OFF", exp_q.size(), 0);

    // R12 repeating long press
    off_sel = 1'b0;
    pb_n = 1'b0; wc(8);
    exp_q.push_back(EV_UP);
    pwr_en = 1'b1;
    push_off(); exp_q.push_back(EV_UP);
    push_off(); exp_q.push_back(EV_UP);
    wc(107);
    chk(ser_en == 1'b1, "R12 active before 8 s", ser_en, 1);
    wc(21);
    chk(!ser_en, "R12 first long-press reset", ser_en, 0);
    wc(104);
    chk(ser_en == 1'b1, "R12 back to active between resets", ser_en, 1);
    wc(24);
    chk(!ser_en, "R12 second long-press reset", ser_en, 0);
    wc(6);
    pb_n = 1'b1; wc(40);
    chk(ser_en == 1'b1 && exp_q.size() == 0, "R12 release ends cycling", exp_q.size(), 0);

    wc(10);
    finish_run();
  end
endmodule